// File: doc/BRIEF.md
# Register-Indirect Conditional Branch Unit

This unit resolves one two-byte conditional branch per strobe for a small processor. The instruction word carries an opcode, a four-bit condition selector and a register number. The selected register is read combinationally from an external register file through `rd_idx`, and the unit compares the selector against the current two-bit condition code. One cycle after the strobe, it reports whether control moves to the register's contents, the address to execute next, and whether the taken target is misaligned.

The block is a four-state machine, with states named for the result they report:
- `ST_IDLE`: no result this cycle.
- `ST_SKIP`: execution falls through.
- `ST_JUMP`: the branch goes to an aligned target.
- `ST_TRAP`: the branch goes to an odd target and the fault is raised.

Every cycle the machine moves to the state chosen by the current input:
- no strobe, or a strobe carrying a foreign opcode → `ST_IDLE`
- a strobe whose condition fails, or whose register field is zero → `ST_SKIP`
- a strobe whose condition holds and whose target is even → `ST_JUMP`
- a strobe whose condition holds and whose target is odd → `ST_TRAP`

Any state can move to any other, because each result lasts one cycle.

Top module: `brcond_unit`

## Requirements
- R1: The instruction is split as opcode `instr[15:8]` (branch opcode 0x07), selector `instr[7:4]` and register field `instr[3:0]`. `rd_idx` equals `instr[3:0]` in the same cycle.
- R2: Selector bit `instr[7]` enables condition code 0, `instr[6]` enables code 1, `instr[5]` enables code 2 and `instr[4]` enables code 3. The branch is taken exactly when the bit for the current `cc` is set and the register field is nonzero.
- R3: A selector of 0xF branches for every condition code when the register field is nonzero. A selector of 0x0 never branches.
- R4: A register field of zero makes the instruction a no-op for any selector and any register data: `taken` is 0, `fault` is 0 and `next_addr` is `cur_addr`+2.
- R5: On a taken branch, `next_addr` equals `reg_data`.
- R6: On an untaken branch, `next_addr` equals `cur_addr`+2, wrapping modulo 2^ADDR_W.
- R7: `fault` is 1 only for a taken branch whose `reg_data` bit 0 is 1. In that case `taken` is also 1 and `next_addr` is `reg_data`.
- R8: A strobe whose opcode is not 0x07 yields `out_valid`=0, `taken`=0 and `fault`=0, and leaves `next_addr` unchanged.
- R9: Results appear in the cycle after the `in_valid` strobe and last one cycle. With no strobe, `out_valid`, `taken` and `fault` are 0.
- R10: After reset, `out_valid`, `taken` and `fault` are 0 and `next_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Instruction strobe |
| instr | input | 16 | Instruction word |
| cc | input | 2 | Current condition code |
| reg_data | input | ADDR_W | Contents of register `rd_idx` |
| cur_addr | input | ADDR_W | Address of this instruction |
| rd_idx | output | 4 | Register file read index |
| out_valid | output | 1 | Result valid |
| taken | output | 1 | Branch taken |
| next_addr | output | ADDR_W | Address to execute next |
| fault | output | 1 | Taken target is odd |

## Verification
The bench builds the unit with ADDR_W set to 16 rather than the default 24. This brings the fall-through wrap from 0xFFFE to 0x0000 within a short directed test. It also makes every target value easy to read in a failure line. All sixteen pairings of a one-hot selector with the four condition codes are run, so any swap in the selector-bit mapping shows up.

// File: rtl/brc_pkg.sv
package brc_pkg;
    localparam int OPC_W  = 8;
    localparam int SEL_W  = 4;
    localparam int RIDX_W = 4;
    localparam int INSN_W = OPC_W + SEL_W + RIDX_W;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SKIP = 2'd1,
        ST_JUMP = 2'd2,
        ST_TRAP = 2'd3
    } brc_state_e;

    typedef struct packed {
        logic              is_branch;
        logic [SEL_W-1:0]  sel;
        logic [RIDX_W-1:0] ridx;
    } brc_fields_t;
endpackage

// File: rtl/brc_decode.sv
module brc_decode
    import brc_pkg::*;
#(
    parameter logic [OPC_W-1:0] OPCODE = 8'h07
) (
    input  logic [INSN_W-1:0] instr,
    output brc_fields_t       fields
);
    localparam int OPC_LSB = SEL_W + RIDX_W;

    always_comb begin
        fields.is_branch = (instr[INSN_W-1:OPC_LSB] == OPCODE);
        fields.sel       = instr[OPC_LSB-1:RIDX_W];
        fields.ridx      = instr[RIDX_W-1:0];
    end
endmodule

// File: rtl/brc_cond_eval.sv
module brc_cond_eval
    import brc_pkg::*;
#(
    parameter int CC_W = 2
) (
    input  logic [(1<<CC_W)-1:0] sel,
    input  logic [CC_W-1:0]      cc,
    input  logic [RIDX_W-1:0]    ridx,
    output logic                 go
);
    localparam int NCODES = 1 << CC_W;

    logic [NCODES-1:0] hit;

    // The most significant selector bit enables condition code 0.
    for (genvar i = 0; i < NCODES; i++) begin : g_code
        assign hit[i] = sel[NCODES-1-i] && (cc == CC_W'(i));
    end

    assign go = (|hit) && (|ridx);
endmodule

// File: rtl/brc_target.sv
module brc_target #(
    parameter int ADDR_W = 24,
    parameter int STEP   = 2
) (
    input  logic              go,
    input  logic [ADDR_W-1:0] reg_data,
    input  logic [ADDR_W-1:0] cur_addr,
    output logic [ADDR_W-1:0] target,
    output logic              misalign
);
    assign target   = go ? reg_data : cur_addr + ADDR_W'(STEP);
    assign misalign = go && reg_data[0];
endmodule

// File: rtl/brcond_unit.sv
module brcond_unit
    import brc_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int CC_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [15:0]       instr,
    input  logic [CC_W-1:0]   cc,
    input  logic [ADDR_W-1:0] reg_data,
    input  logic [ADDR_W-1:0] cur_addr,
    output logic [3:0]        rd_idx,
    output logic              out_valid,
    output logic              taken,
    output logic [ADDR_W-1:0] next_addr,
    output logic              fault
);
    brc_fields_t       fields;
    logic              go;
    logic              misalign;
    logic [ADDR_W-1:0] target;
    logic              accept;
    brc_state_e        state_q, state_d;
    logic [ADDR_W-1:0] addr_q;

    brc_decode #(.OPCODE(8'h07)) u_decode (
        .instr  (instr),
        .fields (fields)
    );

    brc_cond_eval #(.CC_W(CC_W)) u_cond (
        .sel  (fields.sel),
        .cc   (cc),
        .ridx (fields.ridx),
        .go   (go)
    );

    brc_target #(.ADDR_W(ADDR_W), .STEP(2)) u_target (
        .go       (go),
        .reg_data (reg_data),
        .cur_addr (cur_addr),
        .target   (target),
        .misalign (misalign)
    );

    assign rd_idx = fields.ridx;
    assign accept = in_valid && fields.is_branch;

    // Next state chosen by the current input.
    always_comb begin
        state_d = ST_IDLE;
        if (accept) begin
            if (!go)
                state_d = ST_SKIP;
            else if (misalign)
                state_d = ST_TRAP;
            else
                state_d = ST_JUMP;
        end
    end

    // State register and the address that goes with it.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            if (accept)
                addr_q <= target;
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        out_valid = 1'b0;
        taken     = 1'b0;
        fault     = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_SKIP: out_valid = 1'b1;
            ST_JUMP: begin
                out_valid = 1'b1;
                taken     = 1'b1;
            end
            ST_TRAP: begin
                out_valid = 1'b1;
                taken     = 1'b1;
                fault     = 1'b1;
            end
        endcase
    end

    assign next_addr = addr_q;
endmodule

// File: rtl/brcond_unit_chk.sv
module brcond_unit_chk #(
    parameter int ADDR_W = 24,
    parameter int CC_W   = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [15:0]       instr,
    input logic [CC_W-1:0]   cc,
    input logic [ADDR_W-1:0] reg_data,
    input logic [ADDR_W-1:0] cur_addr,
    input logic              out_valid,
    input logic              taken,
    input logic [ADDR_W-1:0] next_addr,
    input logic              fault
);
    AST_BRANCH_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && instr[15:8] == 8'h07) |=> out_valid); // R9

    AST_QUIET_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !taken && !fault)); // R9

    AST_FOREIGN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && instr[15:8] != 8'h07) |=> (!out_valid && !taken && $stable(next_addr))); // R8

    AST_ZERO_REG_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && instr[15:8] == 8'h07 && instr[3:0] == 4'd0)
        |=> (!taken && !fault && next_addr == $past(cur_addr) + ADDR_W'(2))); // R4

    AST_ZERO_SEL_NEVER: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && instr[7:4] == 4'd0) |=> !taken); // R3

    AST_TAKEN_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && instr[15:8] == 8'h07) |=> (!taken || next_addr == $past(reg_data))); // R5

    AST_FAULT_NEEDS_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (taken && next_addr[0])); // R7
endmodule

bind brcond_unit brcond_unit_chk #(.ADDR_W(ADDR_W), .CC_W(CC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .instr     (instr),
    .cc        (cc),
    .reg_data  (reg_data),
    .cur_addr  (cur_addr),
    .out_valid (out_valid),
    .taken     (taken),
    .next_addr (next_addr),
    .fault     (fault)
);

// File: tb/brcond_unit_tb.sv
module brcond_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [15:0]   instr = '0;
    logic [1:0]    cc = '0;
    logic [AW-1:0] reg_data = '0;
    logic [AW-1:0] cur_addr = '0;
    logic [3:0]    rd_idx;
    logic          out_valid, taken, fault;
    logic [AW-1:0] next_addr;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    brcond_unit #(.ADDR_W(AW), .CC_W(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr), .cc(cc),
        .reg_data(reg_data), .cur_addr(cur_addr), .rd_idx(rd_idx),
        .out_valid(out_valid), .taken(taken), .next_addr(next_addr), .fault(fault)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Presents one strobe; returns at the negedge after the capturing edge.
    task automatic issue(input logic [15:0] i, input logic [1:0] c,
                         input logic [AW-1:0] rd, input logic [AW-1:0] ca);
        @(negedge clk);
        instr = i; cc = c; reg_data = rd; cur_addr = ca; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    function automatic logic [15:0] mk(input logic [7:0] op, input logic [3:0] s, input logic [3:0] r);
        return {op, s, r};
    endfunction

    task automatic t_reset;
        chk("R10 out_valid", out_valid, 0);
        chk("R10 taken", taken, 0);
        chk("R10 fault", fault, 0);
        chk("R10 next_addr", next_addr, 0);
    endtask

    task automatic t_fields;
        @(negedge clk);
        instr = mk(8'h07, 4'hA, 4'h5);
        #1 chk("R1 rd_idx", rd_idx, 5);
        instr = mk(8'h07, 4'h3, 4'hC);
        #1 chk("R1 rd_idx", rd_idx, 12);
    endtask

    task automatic t_sel_map;
        for (int s = 0; s < 4; s++) begin
            for (int c = 0; c < 4; c++) begin
                logic [3:0] sel = 4'b1000 >> s;
                logic exp_t = (s == c);
                issue(mk(8'h07, sel, 4'h6), 2'(c), 16'h4000 + AW'(s*16), 16'h1000);
                chk("R2 out_valid", out_valid, 1);
                chk("R2 taken", taken, exp_t);
                if (exp_t) chk("R5 next_addr", next_addr, 16'h4000 + 32'(s*16));
                else       chk("R6 next_addr", next_addr, 16'h1002);
            end
        end
    endtask

    task automatic t_all_none;
        for (int c = 0; c < 4; c++) begin
            issue(mk(8'h07, 4'hF, 4'h9), 2'(c), 16'h2468, 16'h0100);
            chk("R3 full selector taken", taken, 1);
            chk("R5 target", next_addr, 16'h2468);
            issue(mk(8'h07, 4'h0, 4'h9), 2'(c), 16'h2468, 16'h0100);
            chk("R3 empty selector taken", taken, 0);
            chk("R6 fallthrough", next_addr, 16'h0102);
        end
    endtask

    task automatic t_reg_zero;
        issue(mk(8'h07, 4'hF, 4'h0), 2'd2, 16'h3333, 16'h0200);
        chk("R4 taken", taken, 0);
        chk("R4 fault", fault, 0);
        chk("R4 next_addr", next_addr, 16'h0202);
        chk("R4 out_valid", out_valid, 1);
    endtask

    task automatic t_odd;
        issue(mk(8'h07, 4'hF, 4'h3), 2'd1, 16'h5001, 16'h0300);
        chk("R7 fault", fault, 1);
        chk("R7 taken", taken, 1);
        chk("R7 next_addr", next_addr, 16'h5001);
        issue(mk(8'h07, 4'h8, 4'h3), 2'd1, 16'h5001, 16'h0300);
        chk("R7 untaken odd no fault", fault, 0);
        issue(mk(8'h07, 4'h4, 4'h3), 2'd1, 16'h5002, 16'h0300);
        chk("R7 even no fault", fault, 0);
    endtask

    task automatic t_foreign;
        issue(mk(8'h07, 4'hF, 4'h2), 2'd0, 16'h7770, 16'h0400);
        chk("R5 setup", next_addr, 16'h7770);
        issue(mk(8'h47, 4'hF, 4'h2), 2'd0, 16'h1110, 16'h0500);
        chk("R8 out_valid", out_valid, 0);
        chk("R8 taken", taken, 0);
        chk("R8 fault", fault, 0);
        chk("R8 next_addr held", next_addr, 16'h7770);
    endtask

    task automatic t_timing;
        issue(mk(8'h07, 4'h2, 4'h1), 2'd0, 16'h0AA0, 16'hFFFE);
        chk("R6 wrap", next_addr, 16'h0000);
        chk("R9 valid after strobe", out_valid, 1);
        @(negedge clk);
        chk("R9 valid one cycle", out_valid, 0);
        chk("R9 taken quiet", taken, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fields();
        t_sel_map();
        t_all_none();
        t_reg_zero();
        t_odd();
        t_foreign();
        t_timing();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule